// File: doc/BRIEF.md
# Hiccup Overcurrent Protection Logic

This block guards a flyback power switch against hard short circuits: a shorted secondary rectifier, a shorted winding or a saturated transformer. A second current-sense comparator, set above the normal peak limit (trip level 1 V on the sense resistor), delivers a digitized flag. The block qualifies that flag against the switching cycles and the leading-edge blanking window. It stops the converter only when the trip is seen in two switching cycles that follow each other directly.

A single qualified trip is treated as a possible disturbance, for instance an ESD event, and only moves the logic into a warning state. If the following switching cycle runs without a trip, the warning is dropped. If it trips again, the block latches a fault. The latch forces the gate drive low and raises a fault flag for the supply sequencer. The sequencer then lets VCC collapse to its lower post-fault restart level, which gives slow hiccup operation. Only the under-voltage lockout flag clears the latch.

The states are:
- IDLE: no trip pending.
- WARN: a trip was seen in the current cycle.
- CHECK: the cycle directly after a warning is being watched.
- LATCH: the fault is stored.

The transitions are:
- IDLE to WARN on a qualified trip.
- WARN to CHECK at the next cycle start.
- CHECK to LATCH on a qualified trip.
- CHECK to IDLE at the next cycle start without a trip.
- Any state to IDLE while UVLO is high.

Top module: `hiccup_ocp`

## Requirements
- R1: After reset, `fault_o` and `stop_o` are 0, and `gate_drv_o` follows `gate_req_i` while `uvlo_i` is 0.
- R2: A trip sampled during the first LEB_CYC clocks of a gate-on period has no effect. The clock in which the rising edge of `gate_req_i` is first seen counts as the first of these clocks.
- R3: A trip sampled while `gate_req_i` is 0 has no effect.
- R4: A switching cycle with a qualified trip, followed by a full cycle without one, returns the logic to IDLE. The next single trip cycle is then only a new warning.
- R5: Qualified trips in two directly consecutive switching cycles latch the fault. `fault_o` and `stop_o` go to 1, and `gate_drv_o` goes to 0, on the clock edge that samples the second trip.
- R6: Several qualified trips inside one switching cycle count as one trip cycle.
- R7: Once latched, `fault_o` stays 1 whatever `gate_req_i` and `oc_trip_i` do, until `uvlo_i` is sampled high. The clock edge that samples it clears `fault_o`.
- R8: While `uvlo_i` is 1, `stop_o` is 1 and `gate_drv_o` is 0 at once. A pending warning is discarded.
- R9: When `uvlo_i` and the second qualified trip are sampled on the same edge, the UVLO wins and no fault is latched.
- R10: `gate_drv_o` equals `gate_req_i` AND NOT `stop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_req_i | input | 1 | Gate-on request from the PWM logic; its rising edge starts a switching cycle |
| oc_trip_i | input | 1 | Synchronized flag of the short-circuit comparator |
| uvlo_i | input | 1 | 1 while VCC is below the under-voltage lockout threshold |
| gate_drv_o | output | 1 | Gate drive after protection masking |
| stop_o | output | 1 | Converter stopped (fault latched or UVLO) |
| fault_o | output | 1 | Latched fault flag for the supply sequencer |

## Verification
Two functions can fall on the same clock edge. One is the fault decision in CHECK. The other is the UVLO clear that also discards pending warnings. The bench walks the logic into CHECK and then raises `uvlo_i` in the very clock that carries the second trip. It judges the result by `fault_o` staying 0 while `stop_o` is held by UVLO. It then checks that a following single trip cycle is treated as only a first warning. The blanking edge and the gate-off region are swept offset by offset, and every four-cycle trip pattern is swept against a consecutive-ones rule.

// File: rtl/hocp_pkg.sv
package hocp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WARN  = 2'd1,
        ST_CHECK = 2'd2,
        ST_LATCH = 2'd3
    } hocp_state_e;

endpackage

// File: rtl/hocp_leb.sv
module hocp_leb #(
    parameter int LEB_CYC = 25,
    localparam int CNT_W = (LEB_CYC > 1) ? $clog2(LEB_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req,
    output logic cycle_start,
    output logic blank
);

    logic gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_req;
    end

    // switching cycle boundary: first clock of a gate-on period
    assign cycle_start = gate_req & ~gate_q;

    generate
        if (LEB_CYC <= 1) begin : g_single
            assign blank = cycle_start;
        end else begin : g_count
            logic [CNT_W-1:0] remain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    remain <= '0;
                end else if (!gate_req) begin
                    remain <= '0;
                end else if (cycle_start) begin
                    remain <= CNT_W'(LEB_CYC - 1);
                end else if (remain != '0) begin
                    remain <= remain - 1'b1;
                end
            end

            assign blank = cycle_start | (remain != '0);
        end
    endgenerate

endmodule

// File: rtl/hocp_fsm.sv
module hocp_fsm
    import hocp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        uvlo,
    input  logic        cycle_start,
    input  logic        trip_ok,
    output hocp_state_e state
);

    hocp_state_e state_q;
    hocp_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (uvlo) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (trip_ok) state_d = ST_WARN;
                ST_WARN:  if (cycle_start) state_d = ST_CHECK;
                ST_CHECK: begin
                    if (trip_ok)          state_d = ST_LATCH;
                    else if (cycle_start) state_d = ST_IDLE;
                end
                ST_LATCH: state_d = ST_LATCH;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/hiccup_ocp.sv
module hiccup_ocp
    import hocp_pkg::*;
#(
    parameter int LEB_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_req_i,
    input  logic oc_trip_i,
    input  logic uvlo_i,
    output logic gate_drv_o,
    output logic stop_o,
    output logic fault_o
);

    logic        cycle_start;
    logic        leb_active;
    logic        trip_ok;
    hocp_state_e state;

    hocp_leb #(.LEB_CYC(LEB_CYC)) u_leb (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_req    (gate_req_i),
        .cycle_start (cycle_start),
        .blank       (leb_active)
    );

    assign trip_ok = oc_trip_i & gate_req_i & ~leb_active;

    hocp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .uvlo        (uvlo_i),
        .cycle_start (cycle_start),
        .trip_ok     (trip_ok),
        .state       (state)
    );

    always_comb begin
        fault_o    = (state == ST_LATCH);
        stop_o     = fault_o | uvlo_i;
        gate_drv_o = gate_req_i & ~stop_o;
    end

endmodule

// File: rtl/hocp_checker.sv
module hocp_checker (
    input logic clk,
    input logic rst_n,
    input logic gate_req_i,
    input logic oc_trip_i,
    input logic uvlo_i,
    input logic gate_drv_o,
    input logic stop_o,
    input logic fault_o,
    input logic leb_active
);

    AST_GATE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !gate_drv_o); // R10

    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> stop_o); // R5

    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !uvlo_i) |=> fault_o); // R7

    AST_UVLO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> !fault_o); // R8

    AST_FAULT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(oc_trip_i && gate_req_i && !leb_active)); // R2

    AST_UVLO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |-> (stop_o && !gate_drv_o)); // R8

endmodule

bind hiccup_ocp hocp_checker u_hocp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_req_i (gate_req_i),
    .oc_trip_i  (oc_trip_i),
    .uvlo_i     (uvlo_i),
    .gate_drv_o (gate_drv_o),
    .stop_o     (stop_o),
    .fault_o    (fault_o),
    .leb_active (leb_active)
);

// File: tb/test_hiccup_ocp.sv
module test_hiccup_ocp;

    localparam int CLK_PERIOD = 10;
    localparam int LEB = 4;
    localparam int ON_CYC = 10;
    localparam int PER = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_req = 1'b0;
    logic oc_trip = 1'b0;
    logic uvlo = 1'b0;
    logic gate_drv, stop, fault;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hiccup_ocp #(.LEB_CYC(LEB)) i_hiccup_ocp (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_req_i (gate_req),
        .oc_trip_i  (oc_trip),
        .uvlo_i     (uvlo),
        .gate_drv_o (gate_drv),
        .stop_o     (stop),
        .fault_o    (fault)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // one switching cycle: gate on for ON_CYC clocks, trip at offsets in mask
    task automatic run_cycle(input logic [PER-1:0] mask);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            gate_req = (i < ON_CYC);
            oc_trip  = mask[i];
        end
    endtask

    task automatic uvlo_clear();
        @(negedge clk);
        gate_req = 1'b1;
        oc_trip  = 1'b0;
        uvlo     = 1'b1;
        #1;
        check("R8", "stop under uvlo", stop, 1'b1);
        check("R8", "gate masked under uvlo", gate_drv, 1'b0);
        @(negedge clk);
        check("R7", "fault cleared by uvlo", fault, 1'b0);
        uvlo     = 1'b0;
        gate_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "fault after reset", fault, 1'b0);
        check("R1", "stop after reset", stop, 1'b0);
        gate_req = 1'b1;
        #1;
        check("R1", "gate follows request", gate_drv, 1'b1);
        @(negedge clk);
        gate_req = 1'b0;
        repeat (2) @(negedge clk);

        // R2 / R3 sweep of the trip offset within two consecutive cycles
        for (int k = 0; k < PER; k++) begin
            uvlo_clear();
            run_cycle(PER'(1) << k);
            run_cycle(PER'(1) << k);
            run_cycle('0);
            exp = (k >= LEB) && (k < ON_CYC);
            check(k < LEB ? "R2" : (k >= ON_CYC ? "R3" : "R5"), $sformatf("offset %0d fault", k), fault, exp);
            check("R5", $sformatf("offset %0d stop", k), stop, exp);
        end

        // R4 / R5 sweep over every four-cycle trip pattern
        for (int p = 0; p < 16; p++) begin
            uvlo_clear();
            for (int c = 0; c < 4; c++) run_cycle(p[c] ? (PER'(1) << 6) : '0);
            exp = ((p & (p >> 1)) != 0);
            check(exp ? "R5" : "R4", $sformatf("pattern %0d fault", p), fault, exp);
            @(negedge clk);
            gate_req = 1'b1;
            #1;
            check("R10", $sformatf("pattern %0d gate", p), gate_drv, !exp);
            @(negedge clk);
            gate_req = 1'b0;
            repeat (6) @(negedge clk);
        end

        // R6: two trips in one cycle, then a clean cycle
        uvlo_clear();
        run_cycle((PER'(1) << 5) | (PER'(1) << 8));
        run_cycle('0);
        run_cycle(PER'(1) << 6);
        run_cycle('0);
        check("R6", "two trips in one cycle", fault, 1'b0);

        // R5 timing of the fault decision
        uvlo_clear();
        run_cycle(PER'(1) << 6);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (i == 6) check("R5", "no fault before second trip", fault, 1'b0);
            if (i == 7) begin
                check("R5", "fault on second trip edge", fault, 1'b1);
                check("R5", "gate low on second trip edge", gate_drv, 1'b0);
            end
            gate_req = (i < ON_CYC);
            oc_trip  = (i == 6);
        end
        // R7: latch holds against further activity
        run_cycle('1);
        run_cycle('0);
        check("R7", "latch holds", fault, 1'b1);

        // R9: uvlo on the same edge as the second trip
        uvlo_clear();
        run_cycle(PER'(1) << 6);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (i == 7) begin
                check("R9", "uvlo beats fault", fault, 1'b0);
                check("R9", "stop from uvlo", stop, 1'b1);
                uvlo = 1'b0;
            end
            gate_req = (i < ON_CYC);
            oc_trip  = (i == 6);
            if (i == 6) uvlo = 1'b1;
        end
        run_cycle(PER'(1) << 6);
        run_cycle('0);
        check("R8", "warning discarded by uvlo", fault, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule